// File: doc/BRIEF.md
# Serial Audio Output Port

This block turns stereo PCM sample pairs into a three-wire serial audio stream: a bit clock, a word clock that marks left and right halves, and a data line carrying each word MSB first. Sample pairs arrive on a valid/ready handshake into a one-pair holding buffer. Each pair is moved into the shift stage when a new frame begins, which is the word-clock edge that opens the left half. If the buffer is empty at that edge, the previous pair is sent again and an underrun flag is raised.

Six configuration inputs combine to give I2S, left-justified and right-justified framing at 24, 20 or 16 bits. The same framing is available whether the port drives the clocks or follows them. As clock master, the port divides its own clock (nominally 256 times the sample rate) by `MCLK_DIV` to make a bit clock of 64 bit periods per frame. As slave, it synchronises external bit and word clocks into its clock domain and acts on their edges.

The framing engine is a four-state machine:
- **IDLE**: entered from reset. It moves to **SYNC** on the first launch edge that falls in a right half.
- **SYNC**: moves to **LEFT** on the first launch edge in a left half. This is the first frame start.
- **LEFT**: moves to **RIGHT** on a launch edge in a right half (half start).
- **RIGHT**: moves to **LEFT** on a launch edge in a left half (frame start).

A launch edge is the bit-clock edge on which the data line changes.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is held low, `s_ready` is 1, `sdata` is 0 and `underrun` is 0.
- R2: In master mode, `sclk_o` has a period of `MCLK_DIV` clocks. `lrck_o` changes only together with a launch edge, once every `HALF_BITS` bit periods, so a frame lasts 2·HALF_BITS·MCLK_DIV clocks (256 with the defaults).
- R3: With `cfg_edge`=0, `sdata` changes only on falling bit-clock edges; with `cfg_edge`=1, only on rising edges. Data is meant to be captured on the opposite edge.
- R4: With `cfg_lrpol`=0, the left word is sent while the word clock is high; with `cfg_lrpol`=1, the right word is sent while it is high.
- R5: `cfg_wlen` selects the word length: 0 gives 24 bits, 1 gives 20 and 2 gives 16 (3 behaves as 24). Sample words are MSB-aligned in the 24-bit fields, so bits below the selected length are never sent. Words go out MSB first. Every bit slot in a half that holds no data bit is driven 0.
- R6: With `cfg_rjust`=0 (left-justified), the MSB occupies slot 0 of the half when `cfg_delay`=0. When `cfg_delay`=1, the MSB occupies slot 1, which is I2S framing.
- R7: With `cfg_rjust`=1, the LSB occupies the last slot (HALF_BITS−1) of the half and `cfg_delay` has no effect.
- R8: `s_ready` is high exactly when the holding buffer is empty. An accepted pair drops `s_ready` on the next cycle. A `s_valid` offered while `s_ready` is low is ignored.
- R9: At each frame start, a buffered pair is sent in that frame and `underrun` goes to 0. If the buffer is empty, the previous pair is repeated and `underrun` goes to 1. `underrun` changes only at frame starts.
- R10: With `cfg_master`=1, `clk_oe` is 1 and the port drives `sclk_o`/`lrck_o`. With `cfg_master`=0, `clk_oe`, `sclk_o` and `lrck_o` are 0 and framing follows `sclk_i`/`lrck_i`.
- R11: After reset, `sdata` stays 0 until the first right-to-left word-clock transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; master clock in master mode |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_master | input | 1 | 1: drive bit/word clocks; 0: follow external clocks |
| cfg_wlen | input | 2 | Word length code (0:24, 1:20, 2:16) |
| cfg_rjust | input | 1 | 1: right-justified; 0: left-justified |
| cfg_delay | input | 1 | One-bit MSB delay in left-justified mode |
| cfg_edge | input | 1 | Launch edge: 0 falling, 1 rising |
| cfg_lrpol | input | 1 | Word-clock level meaning left/right |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Holding buffer empty |
| s_left | input | SW | Left sample, MSB-aligned |
| s_right | input | SW | Right sample, MSB-aligned |
| sclk_i | input | 1 | External bit clock (slave) |
| lrck_i | input | 1 | External word clock (slave) |
| sclk_o | output | 1 | Generated bit clock (master) |
| lrck_o | output | 1 | Generated word clock (master) |
| clk_oe | output | 1 | Clock drive enable |
| sdata | output | 1 | Serial data |
| underrun | output | 1 | Last frame start found no new pair |

## Verification
The assertions assume that configuration inputs change only while reset is held. They also assume that external slave clocks stay low or high for well over three port clocks, and that each slave word-clock half lasts exactly HALF_BITS bit periods. The stimulus respects all three assumptions:
- Every configuration switch happens under reset.
- The generated slave bit clock has a 16-clock period.
- Word-clock edges are issued only at launch edges, 32 bits apart.

Sample pairs are offered mid-frame, never close to a frame start, so which frame a pair lands in is unambiguous.

// File: rtl/aud_out_pkg.sv
package aud_out_pkg;

    // Framing engine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SYNC  = 2'd1,
        ST_LEFT  = 2'd2,
        ST_RIGHT = 2'd3
    } ser_state_e;

endpackage

// File: rtl/aud_mclk_div.sv
module aud_mclk_div #(
    parameter int DIV       = 4,
    parameter int HALF_BITS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sedge,
    input  logic lrpol,
    output logic sclk_o,
    output logic lrck_o,
    output logic launch_o,
    output logic left_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HW = $clog2(HALF_BITS);
    localparam logic [CW-1:0] C_MID  = CW'(DIV / 2 - 1);
    localparam logic [CW-1:0] C_LAST = CW'(DIV - 1);
    localparam logic [HW-1:0] B_LAST = HW'(HALF_BITS - 1);

    logic [CW-1:0] cnt;
    logic [HW-1:0] bcnt;
    logic          sclk_q;
    logic          lr_q;      // 1 = left half
    logic          toggle;
    logic          wrap;

    assign toggle   = en && (cnt == C_MID || cnt == C_LAST);
    assign launch_o = toggle && ((~sclk_q) == sedge);
    assign wrap     = (bcnt == B_LAST);
    assign left_o   = (launch_o && wrap) ? ~lr_q : lr_q;
    assign sclk_o   = sclk_q;
    assign lrck_o   = en & (lr_q ^ lrpol);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt    <= '0;
            bcnt   <= '0;
            sclk_q <= 1'b0;
            lr_q   <= 1'b0;
        end else begin
            cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
            if (toggle) begin
                sclk_q <= ~sclk_q;
            end
            if (launch_o) begin
                bcnt <= wrap ? '0 : bcnt + 1'b1;
                if (wrap) begin
                    lr_q <= ~lr_q;
                end
            end
        end
    end

    // R2: word clock moves only on a launch edge
    p_lr_on_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !launch_o) |=> $stable(lr_q));

    // R2: two launch edges are never adjacent
    p_launch_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o);

endmodule

// File: rtl/aud_slave_edge.sv
module aud_slave_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic lrck_i,
    input  logic sedge,
    input  logic lrpol,
    output logic launch_o,
    output logic left_o
);
    logic sclk_m, sclk_s, sclk_p;
    logic lr_m, lr_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_m <= 1'b0;
            sclk_s <= 1'b0;
            sclk_p <= 1'b0;
            lr_m   <= 1'b0;
            lr_s   <= 1'b0;
        end else begin
            sclk_m <= sclk_i;
            sclk_s <= sclk_m;
            sclk_p <= sclk_s;
            lr_m   <= lrck_i;
            lr_s   <= lr_m;
        end
    end

    assign launch_o = (sclk_s ^ sclk_p) && (sclk_s == sedge);
    assign left_o   = lr_s ^ lrpol;

    // R10: one launch per external edge
    p_single_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> !launch_o);

endmodule

// File: rtl/aud_serializer.sv
module aud_serializer
    import aud_out_pkg::*;
#(
    parameter int SW        = 24,
    parameter int HALF_BITS = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          left,
    input  logic [1:0]    wlen,
    input  logic          rjust,
    input  logic          dly,
    input  logic          s_valid,
    input  logic [SW-1:0] s_left,
    input  logic [SW-1:0] s_right,
    output logic          s_ready,
    output logic          sdata,
    output logic          underrun
);
    localparam int SLW = $clog2(2 * HALF_BITS);
    localparam logic [SLW-1:0] SLOT_MAX = SLW'(2 * HALF_BITS - 1);

    ser_state_e     state, state_nx;
    logic [SLW-1:0] slot, slot_nx;
    logic [SW-1:0]  hold_l, hold_r, cur_l, cur_r, use_l, use_r;
    logic           full, accept, frame_start, half_start, sdata_nx;
    int             wbits;

    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'd1:    return SW - 4;
            2'd2:    return SW - 8;
            default: return SW;
        endcase
    endfunction

    function automatic logic pick(input logic [SW-1:0] smp, input int pos,
                                  input int wb, input logic rj, input logic dl);
        int k;
        k = rj ? pos - (HALF_BITS - wb) : pos - (dl ? 1 : 0);
        if (k >= 0 && k < wb) return smp[SW-1-k];
        else                  return 1'b0;
    endfunction

    assign wbits       = word_bits(wlen);
    assign accept      = s_valid && !full;
    assign s_ready     = !full;
    assign frame_start = launch && left && (state == ST_SYNC || state == ST_RIGHT);
    assign half_start  = launch && !left && (state == ST_LEFT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (launch && !left) state_nx = ST_SYNC;
            ST_SYNC:  if (launch &&  left) state_nx = ST_LEFT;
            ST_LEFT:  if (launch && !left) state_nx = ST_RIGHT;
            ST_RIGHT: if (launch &&  left) state_nx = ST_LEFT;
        endcase
    end

    always_comb begin
        if (frame_start || half_start) slot_nx = '0;
        else if (slot == SLOT_MAX)     slot_nx = slot;
        else                           slot_nx = slot + 1'b1;
        use_l = (frame_start && full) ? hold_l : cur_l;
        use_r = (frame_start && full) ? hold_r : cur_r;
        unique case (state_nx)
            ST_LEFT:  sdata_nx = pick(use_l, int'(slot_nx), wbits, rjust, dly);
            ST_RIGHT: sdata_nx = pick(use_r, int'(slot_nx), wbits, rjust, dly);
            default:  sdata_nx = 1'b0;
        endcase
    end

    // Outputs and data path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot     <= '0;
            sdata    <= 1'b0;
            underrun <= 1'b0;
            full     <= 1'b0;
            hold_l   <= '0;
            hold_r   <= '0;
            cur_l    <= '0;
            cur_r    <= '0;
        end else begin
            if (launch) begin
                slot  <= slot_nx;
                sdata <= sdata_nx;
            end
            if (frame_start) begin
                cur_l    <= use_l;
                cur_r    <= use_r;
                underrun <= !full;
            end
            if (accept) begin
                hold_l <= s_left;
                hold_r <= s_right;
                full   <= 1'b1;
            end else if (frame_start && full) begin
                full <= 1'b0;
            end
        end
    end

    // R3: data moves only on the launch edge
    p_sdata_on_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !launch |=> $stable(sdata));

    // R8: an accepted pair closes the buffer
    p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    // R9: underrun only updates at a frame start
    p_underrun_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(underrun));

    // R11: silent until the first frame start
    p_quiet_before_sync_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_SYNC) |-> !sdata);

endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx #(
    parameter int SW        = 24,
    parameter int HALF_BITS = 32,
    parameter int MCLK_DIV  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_master,
    input  logic [1:0]    cfg_wlen,
    input  logic          cfg_rjust,
    input  logic          cfg_delay,
    input  logic          cfg_edge,
    input  logic          cfg_lrpol,
    input  logic          s_valid,
    output logic          s_ready,
    input  logic [SW-1:0] s_left,
    input  logic [SW-1:0] s_right,
    input  logic          sclk_i,
    input  logic          lrck_i,
    output logic          sclk_o,
    output logic          lrck_o,
    output logic          clk_oe,
    output logic          sdata,
    output logic          underrun
);
    logic m_launch, m_left, s_launch, s_left_ch;
    logic launch, left;

    aud_mclk_div #(.DIV(MCLK_DIV), .HALF_BITS(HALF_BITS)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_master),
        .sedge    (cfg_edge),
        .lrpol    (cfg_lrpol),
        .sclk_o   (sclk_o),
        .lrck_o   (lrck_o),
        .launch_o (m_launch),
        .left_o   (m_left)
    );

    aud_slave_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_i   (sclk_i),
        .lrck_i   (lrck_i),
        .sedge    (cfg_edge),
        .lrpol    (cfg_lrpol),
        .launch_o (s_launch),
        .left_o   (s_left_ch)
    );

    assign launch = cfg_master ? m_launch : s_launch;
    assign left   = cfg_master ? m_left   : s_left_ch;
    assign clk_oe = cfg_master;

    aud_serializer #(.SW(SW), .HALF_BITS(HALF_BITS)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .left     (left),
        .wlen     (cfg_wlen),
        .rjust    (cfg_rjust),
        .dly      (cfg_delay),
        .s_valid  (s_valid),
        .s_left   (s_left),
        .s_right  (s_right),
        .s_ready  (s_ready),
        .sdata    (sdata),
        .underrun (underrun)
    );

    // R10: slave mode leaves clock outputs quiet
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |=> (!sclk_o && !lrck_o));

endmodule

// File: tb/sim_aud_serial_tx.sv
`timescale 1ns/1ps
module sim_aud_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b1, cfg_rjust = 1'b0, cfg_delay = 1'b0, cfg_edge = 1'b0, cfg_lrpol = 1'b0;
    logic [1:0]  cfg_wlen = 2'd0;
    logic        s_valid = 1'b0;
    logic [23:0] s_left = '0, s_right = '0;
    logic        sclk_i = 1'b0, lrck_i = 1'b0;
    logic        s_ready, sclk_o, lrck_o, clk_oe, sdata, underrun;

    int nvec = 0, nerr = 0;
    int cyc = 0;

    // monitor state
    bit          mon_en = 0, have_prev = 0, prev_left = 0, prev_sclk = 0, synced = 0;
    bit          have_start = 0, slave_run = 0;
    logic [31:0] capt = '0;
    int          nbits = 0, frame_cnt = 0, last_start = 0;
    logic [23:0] cur_l = '0, cur_r = '0, pend_l = '0, pend_r = '0;
    bit          pend_v = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    aud_serial_tx u0 (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wlen(cfg_wlen),
        .cfg_rjust(cfg_rjust), .cfg_delay(cfg_delay), .cfg_edge(cfg_edge),
        .cfg_lrpol(cfg_lrpol), .s_valid(s_valid), .s_ready(s_ready),
        .s_left(s_left), .s_right(s_right), .sclk_i(sclk_i), .lrck_i(lrck_i),
        .sclk_o(sclk_o), .lrck_o(lrck_o), .clk_oe(clk_oe), .sdata(sdata),
        .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        if (c == 2'd1) return 20;
        if (c == 2'd2) return 16;
        return 24;
    endfunction

    // R5 R6 R7: expected slot pattern of one half, slot 0 at bit 31
    function automatic logic [31:0] exp_half(input logic [23:0] s, input int w,
                                             input bit rj, input bit d);
        logic [31:0] r;
        r = '0;
        for (int i = 0; i < 32; i++) begin
            int k;
            k = rj ? i - (32 - w) : i - (d ? 1 : 0);
            r[31-i] = (k >= 0 && k < w) ? s[23-k] : 1'b0;
        end
        return r;
    endfunction

    // capture-edge monitor
    always @(negedge clk) begin
        if (mon_en) begin
            logic ms, ml, is_left;
            ms = cfg_master ? sclk_o : sclk_i;
            ml = cfg_master ? lrck_o : lrck_i;
            if (ms != prev_sclk && ms == ~cfg_edge) begin
                is_left = ml ^ cfg_lrpol;
                if (!have_prev) begin
                    have_prev = 1;
                    prev_left = is_left;
                end else if (is_left != prev_left) begin
                    if (synced) begin
                        // R4 R5 R6 R7: previous half compared against its channel word
                        chk(nbits == 32 && capt == exp_half(prev_left ? cur_l : cur_r,
                            wbits(cfg_wlen), cfg_rjust, cfg_delay),
                            prev_left ? "R4/R5/R6/R7 left" : "R4/R5/R6/R7 right",
                            "half pattern", capt,
                            exp_half(prev_left ? cur_l : cur_r, wbits(cfg_wlen), cfg_rjust, cfg_delay));
                    end
                    if (is_left) begin
                        if (cfg_master && have_start)
                            chk(cyc - last_start == 256, "R2", "frame length", cyc - last_start, 256);
                        have_start = 1;
                        last_start = cyc;
                        synced = 1;
                        // R9: frame start latch or repeat
                        if (pend_v) begin
                            cur_l = pend_l; cur_r = pend_r; pend_v = 0;
                            chk(underrun == 1'b0, "R9", "underrun clear", underrun, 0);
                        end else begin
                            chk(underrun == 1'b1, "R9", "underrun set", underrun, 1);
                        end
                        frame_cnt++;
                    end
                    nbits = 0;
                    capt = '0;
                    prev_left = is_left;
                end
                if (synced) begin
                    capt = {capt[30:0], sdata};
                    nbits++;
                end else begin
                    chk(sdata == 1'b0, "R11", "sdata before sync", sdata, 0);
                end
            end
            prev_sclk = ms;
        end
    end

    // external clock source for slave runs
    initial forever begin
        wait (slave_run);
        while (slave_run) begin
            for (int h = 0; h < 2; h++) begin
                for (int b = 0; b < 32; b++) begin
                    @(posedge clk); #2;
                    if (b == 0) lrck_i = (h == 1) ^ cfg_lrpol;
                    sclk_i = cfg_edge;
                    repeat (8) @(posedge clk); #2;
                    sclk_i = ~cfg_edge;
                    repeat (7) @(posedge clk);
                end
            end
        end
    end

    task automatic send(input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        chk(s_ready == 1'b1, "R8", "ready before offer", s_ready, 1);
        s_valid = 1'b1; s_left = l; s_right = r;
        @(negedge clk);
        s_valid = 1'b0;
        chk(s_ready == 1'b0, "R8", "ready after accept", s_ready, 0);
        pend_l = l; pend_r = r; pend_v = 1;
    endtask

    task automatic run_cfg(input bit m, input logic [1:0] wl, input bit rj, input bit dl,
                           input bit se, input bit lp, input int nfr, input int skip,
                           input bit ignore_test);
        mon_en = 0;
        rst_n = 1'b0;
        cfg_master = m; cfg_wlen = wl; cfg_rjust = rj; cfg_delay = dl;
        cfg_edge = se; cfg_lrpol = lp;
        sclk_i = ~se; lrck_i = lp;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(s_ready == 1'b1, "R1", "s_ready in reset", s_ready, 1);
        chk(sdata == 1'b0, "R1", "sdata in reset", sdata, 0);
        chk(underrun == 1'b0, "R1", "underrun in reset", underrun, 0);
        // R10 clock direction
        chk(clk_oe == m, "R10", "clk_oe", clk_oe, m);
        if (!m) chk(sclk_o == 1'b0 && lrck_o == 1'b0, "R10", "slave clocks quiet",
                    {sclk_o, lrck_o}, 0);
        have_prev = 0; synced = 0; have_start = 0; nbits = 0; capt = '0;
        frame_cnt = 0; pend_v = 0; cur_l = '0; cur_r = '0;
        prev_sclk = m ? 1'b0 : ~se;
        rst_n = 1'b1;
        mon_en = 1;
        if (!m) slave_run = 1;
        send(24'hFFFFFF, 24'h800001);
        for (int f = 0; f < nfr; f++) begin
            int fc;
            fc = frame_cnt;
            while (frame_cnt == fc) @(negedge clk);
            repeat (6) @(negedge clk);
            if (f != skip) begin
                send($urandom(), $urandom());
                if (ignore_test && f == 1) begin
                    @(negedge clk);
                    chk(s_ready == 1'b0, "R8", "ready while full", s_ready, 0);
                    s_valid = 1'b1; s_left = 24'h5A5A5A; s_right = 24'hA5A5A5;
                    @(negedge clk);
                    s_valid = 1'b0;
                end
            end
        end
        begin
            int fc;
            fc = frame_cnt;
            while (frame_cnt == fc) @(negedge clk);
        end
        mon_en = 0;
        slave_run = 0;
        repeat (40) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd4242));
        run_cfg(1, 2'd0, 0, 1, 0, 0, 6, 3, 1);  // I2S 24-bit, underrun in frame 3
        run_cfg(1, 2'd1, 0, 0, 1, 0, 5, -1, 0); // left-justified 20-bit, rising launch
        run_cfg(1, 2'd2, 1, 1, 0, 1, 5, 2, 0);  // right-justified 16-bit, delay ignored
        run_cfg(1, 2'd0, 1, 0, 1, 1, 4, -1, 0); // right-justified 24-bit
        run_cfg(0, 2'd0, 0, 1, 0, 0, 4, 1, 1);  // slave I2S 24-bit
        run_cfg(0, 2'd2, 0, 0, 1, 1, 3, -1, 0); // slave left-justified 16-bit
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nvec++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule